// File: doc/BRIEF.md
# Stall-Until-Cleared Peripheral Call Unit

This unit sits beside a small processor. It lets a program hand a job to a peripheral by executing a no-operation instruction that carries a 5-bit call code. A code of zero leaves the instruction as a plain no-op. Any nonzero code is stored in a call register, and the unit asserts a stall signal that freezes the program counter. The stall holds until the peripheral that owns the code finishes its job and writes zero back into the register.

Two serial peripherals are attached, and both use the same fixed frame. The frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity. Code 1 means receive: the unit waits for the next incoming frame and places its byte on the serial input port. Code 2 means transmit: the unit sends the byte presented on the serial output port. A nonzero code that no peripheral owns is dropped after one cycle, so the processor can never hang on it. The bit time is a whole number of clocks, equal to the clock rate divided by the baud rate. The baud rate defaults to 9600.

Top module: `periph_call_hub`

## Requirements
- R1: After reset, stall is 0, tx_line is 1 (idle) and ser_in_byte is 0.
- R2: A cycle in which nop_valid is 0, or in which nop_valid is 1 with nop_code 0, leaves stall at 0 and leaves every output unchanged.
- R3: When stall is 0 and nop_valid is 1 with a nonzero nop_code, stall is 1 from the next cycle on and stays 1 until the owning peripheral clears the call.
- R4: While stall is 1, any nop_valid and nop_code input is ignored: it neither replaces the pending code nor shortens the stall.
- R5: A code in the range 3 to 31 has no peripheral attached. It holds stall high for exactly one cycle.
- R6: Code 1 (receive) stays pending until a frame arrives with a high stop bit. The line is sampled near mid-bit. On the clock edge that samples the middle of the stop bit, ser_in_byte takes the received byte (first data bit in bit 0) and stall falls on that same edge.
- R7: A frame that completes while no code-1 call is pending is discarded, and ser_in_byte keeps its value.
- R8: Code 2 (transmit) captures ser_out_byte on the edge after the code is latched, and starts the frame on that edge. The frame drives the start bit low, then the data bits with bit 0 first, then the stop bit high. Each bit lasts one bit time. Later changes to ser_out_byte do not alter the frame.
- R9: A code-2 call is cleared only after the whole stop bit has been sent, so stall stays high for exactly 1 + 10 × (bit time) cycles.
- R10: One bit time is CLK_HZ / BAUD clock cycles, and BAUD defaults to 9600.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nop_valid | input | 1 | A no-op instruction is executing this cycle |
| nop_code | input | 5 | Call code carried by that no-op |
| ser_out_byte | input | 8 | Serial output port, the byte to transmit |
| rx_line | input | 1 | Serial receive line, idle high |
| stall | output | 1 | Freeze the program counter |
| ser_in_byte | output | 8 | Serial input port, the last byte received under a call |
| tx_line | output | 1 | Serial transmit line, idle high |

## Verification
The assertions assume that incoming serial frames are well formed and spaced at least one bit time apart. They also assume that the processor never raises nop_valid in the same cycle that a receive frame completes. The bench drives each frame bit for exactly one bit time and follows it with an idle gap. It issues calls only while the line is idle or before a frame begins. A per-cycle behavioural model predicts the exact edge at which each call clears. That model compares stall, the transmit line and the serial input port on every cycle, including the case where codes are pressed during a stall and the case where a frame arrives with no call pending.

// File: rtl/periph_call_pkg.sv
package periph_call_pkg;
    localparam int CODE_W = 5;
    localparam logic [CODE_W-1:0] CODE_IDLE = 5'd0;
    localparam logic [CODE_W-1:0] CODE_RECV = 5'd1;
    localparam logic [CODE_W-1:0] CODE_SEND = 5'd2;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_START = 2'd1,
        SER_DATA  = 2'd2,
        SER_STOP  = 2'd3
    } ser_state_e;
endpackage

// File: rtl/ser_tx_unit.sv
module ser_tx_unit
    import periph_call_pkg::*;
#(
    parameter int BIT_CLKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       line,
    output logic       idle,
    output logic       done
);
    localparam int CNT_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CLKS - 1);

    typedef struct packed {
        ser_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [2:0]      bitn;
        logic [7:0]      shf;
    } tx_t;

    tx_t tx_q, tx_d;

    always_comb begin
        tx_d = tx_q;
        done = 1'b0;
        unique case (tx_q.st)
            SER_IDLE: begin
                if (start) begin
                    tx_d.st  = SER_START;
                    tx_d.cnt = '0;
                    tx_d.shf = data;
                end
            end
            SER_START: begin
                if (tx_q.cnt == CNT_LAST) begin
                    tx_d.st   = SER_DATA;
                    tx_d.cnt  = '0;
                    tx_d.bitn = '0;
                end else begin
                    tx_d.cnt = tx_q.cnt + 1'b1;
                end
            end
            SER_DATA: begin
                if (tx_q.cnt == CNT_LAST) begin
                    tx_d.cnt = '0;
                    tx_d.shf = {1'b0, tx_q.shf[7:1]};
                    if (tx_q.bitn == 3'd7) tx_d.st = SER_STOP;
                    else                   tx_d.bitn = tx_q.bitn + 1'b1;
                end else begin
                    tx_d.cnt = tx_q.cnt + 1'b1;
                end
            end
            SER_STOP: begin
                if (tx_q.cnt == CNT_LAST) begin
                    tx_d.st  = SER_IDLE;
                    tx_d.cnt = '0;
                    done     = 1'b1;
                end else begin
                    tx_d.cnt = tx_q.cnt + 1'b1;
                end
            end
            default: tx_d.st = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '{st: SER_IDLE, cnt: '0, bitn: '0, shf: '0};
        else        tx_q <= tx_d;
    end

    always_comb begin
        unique case (tx_q.st)
            SER_START: line = 1'b0;
            SER_DATA:  line = tx_q.shf[0];
            default:   line = 1'b1;
        endcase
    end
    assign idle = (tx_q.st == SER_IDLE);

    // R8
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle) |=> !line);
endmodule

// File: rtl/ser_rx_unit.sv
module ser_rx_unit
    import periph_call_pkg::*;
#(
    parameter int BIT_CLKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line,
    output logic       done,
    output logic [7:0] data
);
    localparam int CNT_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CLKS - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'((BIT_CLKS / 2) - 1);

    typedef struct packed {
        logic            s1;
        logic            s2;
        ser_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [2:0]      bitn;
        logic [7:0]      shf;
    } rx_t;

    rx_t rx_q, rx_d;

    always_comb begin
        rx_d    = rx_q;
        done    = 1'b0;
        rx_d.s1 = line;
        rx_d.s2 = rx_q.s1;
        unique case (rx_q.st)
            SER_IDLE: begin
                if (!rx_q.s2) begin
                    rx_d.st  = SER_START;
                    rx_d.cnt = '0;
                end
            end
            SER_START: begin
                if (rx_q.cnt == CNT_HALF) begin
                    rx_d.cnt  = '0;
                    rx_d.bitn = '0;
                    rx_d.st   = rx_q.s2 ? SER_IDLE : SER_DATA;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
            SER_DATA: begin
                if (rx_q.cnt == CNT_LAST) begin
                    rx_d.cnt = '0;
                    rx_d.shf = {rx_q.s2, rx_q.shf[7:1]};
                    if (rx_q.bitn == 3'd7) rx_d.st = SER_STOP;
                    else                   rx_d.bitn = rx_q.bitn + 1'b1;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
            SER_STOP: begin
                if (rx_q.cnt == CNT_LAST) begin
                    rx_d.st  = SER_IDLE;
                    rx_d.cnt = '0;
                    done     = rx_q.s2;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
            default: rx_d.st = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '{s1: 1'b1, s2: 1'b1, st: SER_IDLE, cnt: '0, bitn: '0, shf: '0};
        else        rx_q <= rx_d;
    end

    assign data = rx_q.shf;
endmodule

// File: rtl/periph_call_hub.sv
module periph_call_hub
    import periph_call_pkg::*;
#(
    parameter int CLK_HZ = 153600,
    parameter int BAUD   = 9600
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nop_valid,
    input  logic [4:0]  nop_code,
    input  logic [7:0]  ser_out_byte,
    input  logic        rx_line,
    output logic        stall,
    output logic [7:0]  ser_in_byte,
    output logic        tx_line
);
    localparam int BIT_CLKS = CLK_HZ / BAUD;

    typedef struct packed {
        logic [CODE_W-1:0] call;
        logic [7:0]        in_port;
    } hub_t;

    hub_t hub_q, hub_d;

    logic       rx_done;
    logic [7:0] rx_data;
    logic       tx_done;
    logic       tx_idle;
    logic       tx_start;

    ser_rx_unit #(.BIT_CLKS(BIT_CLKS)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (rx_line),
        .done  (rx_done),
        .data  (rx_data)
    );

    assign tx_start = (hub_q.call == CODE_SEND) && tx_idle;

    ser_tx_unit #(.BIT_CLKS(BIT_CLKS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .data  (ser_out_byte),
        .line  (tx_line),
        .idle  (tx_idle),
        .done  (tx_done)
    );

    always_comb begin
        hub_d = hub_q;
        if (hub_q.call == CODE_IDLE) begin
            if (nop_valid && nop_code != CODE_IDLE) hub_d.call = nop_code;
        end else if (hub_q.call == CODE_RECV) begin
            if (rx_done) begin
                hub_d.call    = CODE_IDLE;
                hub_d.in_port = rx_data;
            end
        end else if (hub_q.call == CODE_SEND) begin
            if (tx_done) hub_d.call = CODE_IDLE;
        end else begin
            hub_d.call = CODE_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hub_q <= '{call: CODE_IDLE, in_port: '0};
        else        hub_q <= hub_d;
    end

    assign stall       = (hub_q.call != CODE_IDLE);
    assign ser_in_byte = hub_q.in_port;

    // R2
    zero_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !(nop_valid && nop_code != 5'd0)) |=> !stall);
    // R4
    pending_code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!stall || $stable(hub_q.call)));
    // R5
    orphan_code_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_q.call > CODE_SEND) |=> !stall);
    // R7
    in_port_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_q.call != CODE_RECV) |=> $stable(ser_in_byte));
    // R9
    send_waits_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_q.call == CODE_SEND && !tx_done) |=> (hub_q.call == CODE_SEND));
endmodule

// File: tb/periph_call_hub_tb.sv
module periph_call_hub_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 153600;
    localparam int BAUD       = 9600;
    localparam int BITC       = CLK_HZ / BAUD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nop_valid = 1'b0;
    logic [4:0] nop_code = '0;
    logic [7:0] ser_out_byte = '0;
    logic       rx_line = 1'b1;
    logic       stall;
    logic [7:0] ser_in_byte;
    logic       tx_line;

    periph_call_hub #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .nop_valid    (nop_valid),
        .nop_code     (nop_code),
        .ser_out_byte (ser_out_byte),
        .rx_line      (rx_line),
        .stall        (stall),
        .ser_in_byte  (ser_in_byte),
        .tx_line      (tx_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    running = 1'b0;

    // reference model state
    int       m_call = 0;
    int       m_t = 0;
    int       m_txb = 0;
    int       m_in = 0;
    int       rx_done_cyc = -1;
    int       rx_byte = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_call = 0; m_t = 0; m_in = 0;
        end else if (m_call == 0) begin
            if (nop_valid && nop_code != 0) begin
                m_call = nop_code;
                m_t = 0;
            end
        end else begin
            m_t = m_t + 1;
            if (m_call == 1) begin
                if (cyc == rx_done_cyc) begin
                    m_call = 0;
                    m_in = rx_byte;
                end
            end else if (m_call == 2) begin
                if (m_t == 1) m_txb = ser_out_byte;
                if (m_t == 1 + 10*BITC) m_call = 0;
            end else begin
                m_call = 0;
            end
        end
    end

    function automatic logic exp_tx();
        if (m_call == 2 && m_t >= 1) begin
            if (m_t <= BITC) return 1'b0;
            if (m_t <= 9*BITC) return logic'((m_txb >> ((m_t - BITC - 1) / BITC)) & 1);
            return 1'b1;
        end
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        if (running) begin
            n_vec = n_vec + 1;
            if (stall !== (m_call != 0)) begin
                n_bad = n_bad + 1;
                $display("FAIL %s stall cyc %0d actual %0b expected %0b", tag, cyc, stall, m_call != 0);
            end
            if (tx_line !== exp_tx()) begin
                n_bad = n_bad + 1;
                $display("FAIL %s tx_line cyc %0d actual %0b expected %0b", tag, cyc, tx_line, exp_tx());
            end
            if (ser_in_byte !== 8'(m_in)) begin
                n_bad = n_bad + 1;
                $display("FAIL %s ser_in_byte cyc %0d actual %02h expected %02h", tag, cyc, ser_in_byte, 8'(m_in));
            end
        end
    end

    task automatic issue(input int code);
        @(negedge clk);
        nop_valid = 1'b1;
        nop_code  = 5'(code);
        @(negedge clk);
        nop_valid = 1'b0;
        nop_code  = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b);
        @(negedge clk);
        rx_byte     = b;
        rx_done_cyc = cyc + 1 + 2 + BITC/2 + 9*BITC;
        rx_line     = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (BITC) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (2*BITC) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad = n_bad + 1;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        running = 1'b1;
        tag = "R1";
        idle(2);
        rst_n = 1'b1;
        idle(4);

        tag = "R2";
        @(negedge clk); nop_valid = 1'b1; nop_code = 5'd0;
        idle(3);
        nop_valid = 1'b0; nop_code = 5'd7;
        idle(3);
        nop_code = 5'd0;

        tag = "R5";
        issue(9);
        idle(4);
        issue(31);
        idle(3);
        issue(3);
        idle(3);

        tag = "R3 R8";
        ser_out_byte = 8'hA5;
        issue(2);
        idle(2);
        tag = "R4";
        @(negedge clk); nop_valid = 1'b1; nop_code = 5'd5;
        idle(10);
        nop_valid = 1'b0; nop_code = 5'd0;
        ser_out_byte = 8'h3C;
        tag = "R9 R10";
        idle(10*BITC + 10);

        tag = "R8";
        ser_out_byte = 8'h01;
        issue(2);
        idle(3);
        ser_out_byte = 8'hFF;
        idle(10*BITC + 5);

        tag = "R6";
        issue(1);
        idle(5);
        send_frame(8'h5A);
        idle(5);
        issue(1);
        idle(2);
        send_frame(8'h81);
        idle(5);

        tag = "R7";
        send_frame(8'hC3);
        idle(10);

        tag = "R6";
        issue(1);
        send_frame(8'hFF);
        idle(10);

        running = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule